// File: doc/BRIEF.md
# Split-Pipeline Stall Controller

This block decides, every cycle, which half of an eight-stage instruction pipeline may move forward. The stages are F1, F2, D1 (the fetch half) and D2, R1, R2, X, W (the execute half). The two halves meet at a small instruction queue: the fetch half pushes each instruction that leaves D1, and D2 pops one whenever the execute half moves. The block keeps a valid flag for every stage and an identifying tag for each instruction. It holds the queue, and it drives the advance enables for both halves along with the queue push and pop strobes.

Three active-high ready inputs let slow memory stretch an access. The program-access ready inserts waits while F1 holds an instruction, and the fetch half stops while the execute half carries on. The data-read ready inserts waits while R1 holds an instruction. The data-write ready inserts waits while W holds one. Either of these last two freezes the whole execute half, and the fetch half keeps filling the queue until the queue is full. When the queue is empty, D2 has nothing to load. The execute half then stands still and the fetch half keeps working.

Top module: `pipe_freeze_ctrl`

## Requirements
- R1: A synchronous active-high reset clears every stage valid flag and empties the queue. After reset, front_adv is 1, back_adv is 0 and not_avail is 1.
- R2: In `stage_vld`, bit 0 is F1, bit 1 is F2, bit 2 is D1, bit 3 is D2, bit 4 is R1, bit 5 is R2, bit 6 is X and bit 7 is W. When nothing stalls, an instruction accepted into F1 at one edge is in F2 and then in D1 at the next two edges. On the third edge it is pushed into the queue.
- R3: While F1 is occupied and prog_rdy is low, front_adv is 0 and F1, F2 and D1 keep their contents. An instruction offered on issue_vld during that time is not taken.
- R4: During an F1 wait, if the queue is not empty and no data wait is active, back_adv stays 1 and D2 keeps loading queued instructions.
- R5: While R1 is occupied and rd_rdy is low, back_adv is 0, and D2 through W and d2_tag keep their values.
- R6: While W is occupied and wr_rdy is low, back_adv is 0, even when the queue holds instructions.
- R7: If a read wait and a write wait overlap, the execute half stays frozen until both rd_rdy and wr_rdy are high.
- R8: While the execute half is frozen, the fetch half keeps advancing until the queue holds DEPTH entries (default 4) and D1 is occupied. It then stops, and the occupancy never exceeds DEPTH.
- R9: A push and a pop in the same cycle are allowed, including when the queue is full, and they leave the occupancy unchanged.
- R10: When the queue is empty and no data wait is active, not_avail is 1, back_adv is 0 and no pop occurs. D2 through W hold while the fetch half continues.
- R11: Each pop loads the oldest queued instruction's tag into D2, and that tag appears on d2_tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_vld | input | 1 | New instruction offered to F1 |
| issue_tag | input | TAG_W | Tag of the offered instruction |
| prog_rdy | input | 1 | Program-space access ready (low = wait) |
| rd_rdy | input | 1 | Data-read ready (low = wait) |
| wr_rdy | input | 1 | Data-write ready (low = wait) |
| front_adv | output | 1 | Fetch half (F1..D1) advances this cycle |
| back_adv | output | 1 | Execute half (D2..W) advances this cycle |
| q_push | output | 1 | Instruction leaving D1 enters the queue |
| q_pop | output | 1 | Queue head loads into D2 |
| q_count | output | $clog2(DEPTH+1) | Queue occupancy |
| stage_vld | output | 8 | Per-stage valid flags, F1 at bit 0 to W at bit 7 |
| d2_tag | output | TAG_W | Tag held in the D2 instruction register |
| not_avail | output | 1 | D2 requests but the queue is empty |

## Verification
The bench fills the queue behind a read wait until it is full. It then releases the wait so that the push and the pop fall in the same cycle. A design that blocks the push on a full queue even while a pop happens would lose a cycle, and one that counts wrongly would report 3 or 5 entries instead of 4. An F1 wait is held while the queue still holds work. A design that couples the halves would stop d2_tag from stepping through the queued tags. A design that latches the instruction offered during the wait would later show the wrong tag in D2. Overlapping read and write waits are released one at a time, and a design that resumes on either ready alone would move the execute half one cycle early. An empty queue is checked to freeze D2 through W rather than let the execute half drain.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  localparam int FRONT_N = 3;
  localparam int BACK_N  = 5;
  localparam int NUM_STAGES = FRONT_N + BACK_N;

  localparam int ST_F1 = 0;
  localparam int ST_D1 = 2;
  localparam int ST_R1 = 4;
  localparam int ST_W  = 7;

  // fetch half moves unless F1 waits on memory or D1 has nowhere to go
  function automatic logic front_go(input logic f1_wait, input logic d1_vld,
                                    input logic q_full, input logic q_pop);
    return !f1_wait && !(d1_vld && q_full && !q_pop);
  endfunction

  // execute half moves only with no data wait and an instruction to load
  function automatic logic back_go(input logic r1_wait, input logic w_wait,
                                   input logic q_empty);
    return !r1_wait && !w_wait && !q_empty;
  endfunction
endpackage

// File: rtl/pfc_front.sv
module pfc_front
  import pfc_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               adv,
  input  logic               in_vld,
  input  logic [TAG_W-1:0]   in_tag,
  output logic [FRONT_N-1:0] vld,
  output logic [TAG_W-1:0]   out_tag
);
  logic [TAG_W-1:0] tag_q [FRONT_N];

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else if (adv) vld <= {vld[FRONT_N-2:0], in_vld};
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      tag_q[0] <= in_tag;
      for (int i = 1; i < FRONT_N; i++) tag_q[i] <= tag_q[i-1];
    end
  end

  assign out_tag = tag_q[FRONT_N-1];
endmodule

// File: rtl/pfc_queue.sv
module pfc_queue #(
  parameter int DEPTH = 4,
  parameter int TAG_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic [TAG_W-1:0] wdata,
  output logic [TAG_W-1:0] rdata,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [TAG_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  assign rdata = mem[rd_ptr];
  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
endmodule

// File: rtl/pfc_back.sv
module pfc_back
  import pfc_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic [TAG_W-1:0]  in_tag,
  output logic [BACK_N-1:0] vld,
  output logic [TAG_W-1:0]  d2_tag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld    <= '0;
      d2_tag <= '0;
    end else if (adv) begin
      vld    <= {vld[BACK_N-2:0], 1'b1};
      d2_tag <= in_tag;
    end
  end
endmodule

// File: rtl/pipe_freeze_ctrl.sv
module pipe_freeze_ctrl
  import pfc_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int TAG_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  issue_vld,
  input  logic [TAG_W-1:0]      issue_tag,
  input  logic                  prog_rdy,
  input  logic                  rd_rdy,
  input  logic                  wr_rdy,
  output logic                  front_adv,
  output logic                  back_adv,
  output logic                  q_push,
  output logic                  q_pop,
  output logic [CNT_W-1:0]      q_count,
  output logic [NUM_STAGES-1:0] stage_vld,
  output logic [TAG_W-1:0]      d2_tag,
  output logic                  not_avail
);
  logic [FRONT_N-1:0] front_vld;
  logic [BACK_N-1:0]  back_vld;
  logic [TAG_W-1:0]   d1_tag, head_tag;
  logic               q_full, q_empty;

  // named wait events, visible to the bound checker
  logic f1_wait, r1_wait, w_wait;

  assign stage_vld = {back_vld, front_vld};
  assign f1_wait   = stage_vld[ST_F1] && !prog_rdy;
  assign r1_wait   = stage_vld[ST_R1] && !rd_rdy;
  assign w_wait    = stage_vld[ST_W]  && !wr_rdy;

  assign back_adv  = back_go(r1_wait, w_wait, q_empty);
  assign q_pop     = back_adv;
  assign front_adv = front_go(f1_wait, stage_vld[ST_D1], q_full, q_pop);
  assign q_push    = front_adv && stage_vld[ST_D1];
  assign not_avail = q_empty && !r1_wait && !w_wait;

  pfc_front #(.TAG_W(TAG_W)) u_front (
    .clk(clk), .rst(rst), .adv(front_adv), .in_vld(issue_vld),
    .in_tag(issue_tag), .vld(front_vld), .out_tag(d1_tag)
  );

  pfc_queue #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_queue (
    .clk(clk), .rst(rst), .push(q_push), .pop(q_pop), .wdata(d1_tag),
    .rdata(head_tag), .count(q_count), .full(q_full), .empty(q_empty)
  );

  pfc_back #(.TAG_W(TAG_W)) u_back (
    .clk(clk), .rst(rst), .adv(back_adv), .in_tag(head_tag),
    .vld(back_vld), .d2_tag(d2_tag)
  );
endmodule

// File: rtl/pfc_checker.sv
module pfc_checker #(
  parameter int DEPTH = 4,
  parameter int TAG_W = 8,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             prog_rdy,
  input logic             rd_rdy,
  input logic             wr_rdy,
  input logic             q_push,
  input logic             q_pop,
  input logic [CNT_W-1:0] q_count,
  input logic [7:0]       stage_vld,
  input logic [TAG_W-1:0] d2_tag
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (q_count == '0) && (stage_vld == '0));

  assert_f1_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (stage_vld[0] && !prog_rdy) |=> $stable(stage_vld[2:0]));

  assert_read_freeze_R5: assert property (@(posedge clk) disable iff (rst)
    (stage_vld[4] && !rd_rdy) |=> ($stable(stage_vld[7:3]) && $stable(d2_tag)));

  assert_write_freeze_R6: assert property (@(posedge clk) disable iff (rst)
    (stage_vld[7] && !wr_rdy) |=> ($stable(stage_vld[7:3]) && $stable(d2_tag)));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    q_count <= CNT_W'(DEPTH));

  assert_full_push_R8: assert property (@(posedge clk) disable iff (rst)
    (q_push && q_count == CNT_W'(DEPTH)) |-> q_pop);

  assert_pushpop_R9: assert property (@(posedge clk) disable iff (rst)
    (q_push && q_pop) |=> $stable(q_count));

  assert_empty_nopop_R10: assert property (@(posedge clk) disable iff (rst)
    (q_count == '0) |-> !q_pop);
endmodule

bind pipe_freeze_ctrl pfc_checker #(.DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .prog_rdy(prog_rdy), .rd_rdy(rd_rdy), .wr_rdy(wr_rdy),
  .q_push(q_push), .q_pop(q_pop), .q_count(q_count), .stage_vld(stage_vld),
  .d2_tag(d2_tag)
);

// File: tb/test_pipe_freeze_ctrl.sv
module test_pipe_freeze_ctrl;
  localparam int DEPTH = 4;
  localparam int TAG_W = 8;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic issue_vld = 1'b0;
  logic [TAG_W-1:0] issue_tag = '0;
  logic prog_rdy = 1'b1, rd_rdy = 1'b1, wr_rdy = 1'b1;
  logic front_adv, back_adv, q_push, q_pop, not_avail;
  logic [CNT_W-1:0] q_count;
  logic [7:0] stage_vld;
  logic [TAG_W-1:0] d2_tag;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pipe_freeze_ctrl #(.DEPTH(DEPTH), .TAG_W(TAG_W)) i_pipe_freeze_ctrl (
    .clk(clk), .rst(rst), .issue_vld(issue_vld), .issue_tag(issue_tag),
    .prog_rdy(prog_rdy), .rd_rdy(rd_rdy), .wr_rdy(wr_rdy),
    .front_adv(front_adv), .back_adv(back_adv), .q_push(q_push), .q_pop(q_pop),
    .q_count(q_count), .stage_vld(stage_vld), .d2_tag(d2_tag), .not_avail(not_avail)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic offer(input logic v, input logic [TAG_W-1:0] t);
    issue_vld = v;
    issue_tag = t;
  endtask

  task automatic t_reset();
    rst = 1'b1; offer(1'b0, '0);
    prog_rdy = 1'b1; rd_rdy = 1'b1; wr_rdy = 1'b1;
    tick(); tick();
    rst = 1'b0; #1;
    chk("R1 stage_vld", 32'(stage_vld), 32'h0);
    chk("R1 q_count", 32'(q_count), 32'h0);
    chk("R1 front_adv", 32'(front_adv), 32'h1);
    chk("R1 back_adv", 32'(back_adv), 32'h0);
    chk("R1 not_avail", 32'(not_avail), 32'h1);
  endtask

  task automatic t_flow();
    offer(1'b1, 8'hA5);
    tick(); offer(1'b0, '0); #1;
    chk("R2 F1", 32'(stage_vld), 32'h01);
    tick(); chk("R2 F2", 32'(stage_vld), 32'h02);
    tick(); chk("R2 D1", 32'(stage_vld), 32'h04);
    chk("R2 push", 32'(q_push), 32'h1);
    tick(); chk("R2 queued", 32'(q_count), 32'h1);
    chk("R11 pop", 32'(q_pop), 32'h1);
    tick(); chk("R11 d2_tag", 32'(d2_tag), 32'hA5);
    chk("R10 not_avail", 32'(not_avail), 32'h1);
    chk("R10 back_adv", 32'(back_adv), 32'h0);
    tick(); chk("R10 back held", 32'(stage_vld), 32'h08);
  endtask

  // n0..: three issues, read wait fills queue, then release, then F1 wait
  task automatic t_read_wait_and_f1_wait();
    offer(1'b1, 8'd1); tick();            // n1
    offer(1'b1, 8'd2); tick();            // n2
    offer(1'b1, 8'd3); tick();            // n3
    offer(1'b0, '0); tick(); tick(); tick(); // n6
    rd_rdy = 1'b0; offer(1'b1, 8'd4); #1;
    chk("R5 back_adv", 32'(back_adv), 32'h0);
    chk("R5 not_avail", 32'(not_avail), 32'h0);
    tick(); offer(1'b1, 8'd5);            // n7
    tick(); offer(1'b1, 8'd6);            // n8
    tick(); offer(1'b1, 8'd7);            // n9
    tick(); offer(1'b0, '0);              // n10
    tick(); tick();                       // n12
    chk("R8 full count", 32'(q_count), 32'h4);
    chk("R8 front stopped", 32'(front_adv), 32'h0);
    chk("R8 no push", 32'(q_push), 32'h0);
    chk("R5 stages", 32'(stage_vld), 32'h1C);
    tick();                               // n13
    chk("R8 held full", 32'(q_count), 32'h4);
    chk("R5 d2 frozen", 32'(d2_tag), 32'd2);
    rd_rdy = 1'b1; #1;
    chk("R9 pop", 32'(q_pop), 32'h1);
    chk("R9 push", 32'(q_push), 32'h1);
    tick();                               // n14
    chk("R9 count", 32'(q_count), 32'h4);
    chk("R11 d2 C", 32'(d2_tag), 32'd3);
    chk("R5 released", 32'(stage_vld), 32'h38);
    offer(1'b1, 8'd8);
    tick();                               // n15: H in F1
    prog_rdy = 1'b0; offer(1'b1, 8'd9); #1;
    chk("R3 front_adv", 32'(front_adv), 32'h0);
    chk("R4 back_adv", 32'(back_adv), 32'h1);
    tick();                               // n16
    chk("R4 d2 E", 32'(d2_tag), 32'd5);
    tick();                               // n17
    chk("R3 front held", 32'(stage_vld[2:0]), 32'h1);
    chk("R4 d2 F", 32'(d2_tag), 32'd6);
    chk("R4 count", 32'(q_count), 32'h1);
    prog_rdy = 1'b1; offer(1'b0, '0);
    tick(); tick();                       // n19
    chk("R10 not_avail", 32'(not_avail), 32'h1);
    chk("R10 stages", 32'(stage_vld), 32'hFC);
    chk("R10 front pushes", 32'(q_push), 32'h1);
    tick(); tick();                       // n21
    chk("R3 issue ignored", 32'(d2_tag), 32'd8);
  endtask

  // continues from n21: write wait, then overlapping read and write waits
  task automatic t_write_and_both();
    offer(1'b1, 8'd10); tick();           // n22
    offer(1'b0, '0); wr_rdy = 1'b0; #1;
    chk("R6 not_avail", 32'(not_avail), 32'h0);
    tick(); tick(); tick();               // n25
    chk("R6 queued", 32'(q_count), 32'h1);
    chk("R6 back_adv", 32'(back_adv), 32'h0);
    chk("R6 d2 held", 32'(d2_tag), 32'd8);
    rd_rdy = 1'b0;
    tick();                               // n26
    wr_rdy = 1'b1; #1;
    chk("R7 still frozen", 32'(back_adv), 32'h0);
    tick();                               // n27
    chk("R7 d2 held", 32'(d2_tag), 32'd8);
    rd_rdy = 1'b1; #1;
    chk("R7 resume", 32'(back_adv), 32'h1);
    tick();                               // n28
    chk("R11 d2 J", 32'(d2_tag), 32'd10);
    chk("R7 count", 32'(q_count), 32'h0);
  endtask

  task automatic t_midrun_reset();
    offer(1'b1, 8'd11); tick(); tick();
    offer(1'b0, '0);
    t_reset();
    chk("R1 d2 cleared", 32'(d2_tag), 32'h0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_flow();
    t_reset();
    t_read_wait_and_f1_wait();
    t_write_and_both();
    t_midrun_reset();
    summary();
    $finish;
  end
endmodule